// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Latency Model

This block prices one DRAM access at a time. A requester presents a line address, a read/write flag and a page-policy selection. One cycle after the request is taken, the block returns the number of cycles that access costs. The cost is worked out from a small table that holds one row-buffer entry per bank. Each entry is a valid bit and the row currently held open in that bank.

Three pricing modes are available. In open-page mode a row stays open after use, so the next access to that bank is a hit (column access and bus), an idle-bank access (activate, column access and bus) or a conflict (precharge, activate, column access and bus). In close-page mode every access opens its row and closes it again. In fixed mode every access costs a flat constant and the row buffers are not touched.

The block keeps separate read and write access counters. It also keeps separate running sums of the cycles charged to reads and to writes, so a cache hierarchy model can collect DRAM statistics directly from its ports.

Top module: `dram_row_timer`

## Requirements
- R1: After reset, rspValid is 0, reqReady is 1, all four statistics outputs are 0 and every bank is treated as holding no open row.
- R2: A request is taken in a cycle where reqValid and reqReady are both 1. rspValid rises at the next clock edge and then holds, with rspCycles stable, until a cycle with rspReady = 1. reqReady equals (not rspValid) or rspReady, so a new request can be taken in the same cycle the previous response is consumed.
- R3: With the defaults (32-bit line address, 64-byte lines, 1024-byte rows, 16 banks), line bits [3:0] select the line within a row, bits [7:4] select the bank and bits [31:8] form the row ID.
- R4: With modeSel = 0 (fixed) or 3 (spare, treated as fixed), every access costs 100 cycles and no bank's row-buffer state changes.
- R5: With modeSel = 1 (open page), an access to a bank with no open row costs 100 (activate 45 + column 45 + bus 10), and that bank then holds the accessed row open.
- R6: With modeSel = 1, an access whose row equals the row open in its bank costs 55 (column + bus).
- R7: With modeSel = 1, an access to a bank that holds a different row costs 145 (precharge 45 + activate + column + bus), and the new row replaces the old one.
- R8: With modeSel = 2 (close page), every access costs 100, and the addressed bank holds no open row afterwards.
- R9: rdCount increases by one for each accepted read (reqWrite = 0), and wrCount by one for each accepted write. Both are visible in the same cycle as the response.
- R10: rdDelaySum accumulates the charged cycles of every accepted read, and wrDelaySum those of every accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqLine | input | 32 | Line address of the access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| modeSel | input | 2 | 0 fixed, 1 open page, 2 close page, 3 fixed |
| rspValid | output | 1 | Latency result present |
| rspReady | input | 1 | Requester takes the result |
| rspCycles | output | 8 | Cycles charged to the accepted access |
| rdCount | output | 32 | Number of reads priced |
| wrCount | output | 32 | Number of writes priced |
| rdDelaySum | output | 40 | Cumulative cycles charged to reads |
| wrDelaySum | output | 40 | Cumulative cycles charged to writes |

## Verification
Two things can happen in the same cycle: a pending response is consumed and the next request is taken. In that cycle the row-buffer table must already reflect the earlier access. The bench provokes this by keeping rspReady high while a second request to the same row follows immediately. It judges the result by requiring that the second response arrives the very next cycle and is priced as an open-row hit (55), not as an idle-bank access. A separate hold test keeps rspReady low for several cycles and checks that reqReady stays low and rspCycles does not move.

// File: rtl/dram_row_timer_pkg.sv
package dram_row_timer_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_OPEN  = 2'd1,
    MODE_CLOSE = 2'd2,
    MODE_SPARE = 2'd3
  } pageMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/dram_row_timer_ctrl.sv
module dram_row_timer_ctrl
  import dram_row_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  input  logic        rspReady,
  output ctrlStrobe_t strobe
);

  logic pending;

  assign reqReady      = !pending || rspReady;
  assign strobe.accept = reqValid && reqReady;
  assign rspValid      = pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.accept) begin
      pending <= 1'b1;
    end else if (rspReady) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_row_timer_dp.sv
module dram_row_timer_dp
  import dram_row_timer_pkg::*;
#(
  parameter int LINE_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ROW_BYTES  = 1024,
  parameter int NUM_BANKS  = 16,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 32,
  parameter int SUM_W      = 40,
  parameter int T_ACT      = 45,
  parameter int T_CAS      = 45,
  parameter int T_PRE      = 45,
  parameter int T_BUS      = 10,
  parameter int FIXED_LAT  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqWrite,
  input  pageMode_e         pageMode,
  output logic [LAT_W-1:0]  rspCycles,
  output logic [CNT_W-1:0]  rdCount,
  output logic [CNT_W-1:0]  wrCount,
  output logic [SUM_W-1:0]  rdDelaySum,
  output logic [SUM_W-1:0]  wrDelaySum
);

  localparam int OFF_W  = $clog2(ROW_BYTES / LINE_BYTES);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = LINE_W - OFF_W - BANK_W;

  localparam logic [LAT_W-1:0] LAT_HIT   = LAT_W'(T_CAS + T_BUS);
  localparam logic [LAT_W-1:0] LAT_IDLE  = LAT_W'(T_ACT + T_CAS + T_BUS);
  localparam logic [LAT_W-1:0] LAT_CONF  = LAT_W'(T_PRE + T_ACT + T_CAS + T_BUS);
  localparam logic [LAT_W-1:0] LAT_FIXED = LAT_W'(FIXED_LAT);

  logic [BANK_W-1:0] bankSel;
  logic [ROW_W-1:0]  rowSel;
  logic [OFF_W-1:0]  unusedOffset;

  assign unusedOffset = reqLine[OFF_W-1:0];
  assign bankSel      = reqLine[OFF_W +: BANK_W];
  assign rowSel       = reqLine[LINE_W-1 -: ROW_W];

  logic             rowValid [NUM_BANKS];
  logic [ROW_W-1:0] rowId    [NUM_BANKS];

  // per-bank row-buffer entries
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitThis;
    assign hitThis = strobe.accept && (bankSel == BANK_W'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowValid[b] <= 1'b0;
        rowId[b]    <= '0;
      end else if (hitThis) begin
        if (pageMode == MODE_OPEN) begin
          rowValid[b] <= 1'b1;
          rowId[b]    <= rowSel;
        end else if (pageMode == MODE_CLOSE) begin
          rowValid[b] <= 1'b0;
        end
      end
    end
  end

  logic             selValid;
  logic [ROW_W-1:0] selRow;
  logic [LAT_W-1:0] latNext;

  assign selValid = rowValid[bankSel];
  assign selRow   = rowId[bankSel];

  always_comb begin
    unique case (pageMode)
      MODE_OPEN: begin
        if (!selValid)             latNext = LAT_IDLE;
        else if (selRow == rowSel) latNext = LAT_HIT;
        else                       latNext = LAT_CONF;
      end
      MODE_CLOSE: latNext = LAT_IDLE;
      default:    latNext = LAT_FIXED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspCycles  <= '0;
      rdCount    <= '0;
      wrCount    <= '0;
      rdDelaySum <= '0;
      wrDelaySum <= '0;
    end else if (strobe.accept) begin
      rspCycles <= latNext;
      if (reqWrite) begin
        wrCount    <= wrCount + 1'b1;
        wrDelaySum <= wrDelaySum + SUM_W'(latNext);
      end else begin
        rdCount    <= rdCount + 1'b1;
        rdDelaySum <= rdDelaySum + SUM_W'(latNext);
      end
    end
  end

endmodule

// File: rtl/dram_row_timer.sv
module dram_row_timer
  import dram_row_timer_pkg::*;
#(
  parameter int LINE_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ROW_BYTES  = 1024,
  parameter int NUM_BANKS  = 16,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 32,
  parameter int SUM_W      = 40,
  parameter int T_ACT      = 45,
  parameter int T_CAS      = 45,
  parameter int T_PRE      = 45,
  parameter int T_BUS      = 10,
  parameter int FIXED_LAT  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqWrite,
  input  logic [1:0]        modeSel,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [LAT_W-1:0]  rspCycles,
  output logic [CNT_W-1:0]  rdCount,
  output logic [CNT_W-1:0]  wrCount,
  output logic [SUM_W-1:0]  rdDelaySum,
  output logic [SUM_W-1:0]  wrDelaySum
);

  ctrlStrobe_t strobe;
  pageMode_e   pageMode;

  assign pageMode = pageMode_e'(modeSel);

  dram_row_timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strobe   (strobe)
  );

  dram_row_timer_dp #(
    .LINE_W     (LINE_W),
    .LINE_BYTES (LINE_BYTES),
    .ROW_BYTES  (ROW_BYTES),
    .NUM_BANKS  (NUM_BANKS),
    .LAT_W      (LAT_W),
    .CNT_W      (CNT_W),
    .SUM_W      (SUM_W),
    .T_ACT      (T_ACT),
    .T_CAS      (T_CAS),
    .T_PRE      (T_PRE),
    .T_BUS      (T_BUS),
    .FIXED_LAT  (FIXED_LAT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqLine    (reqLine),
    .reqWrite   (reqWrite),
    .pageMode   (pageMode),
    .rspCycles  (rspCycles),
    .rdCount    (rdCount),
    .wrCount    (wrCount),
    .rdDelaySum (rdDelaySum),
    .wrDelaySum (wrDelaySum)
  );

endmodule

// File: rtl/dram_row_timer_chk.sv
module dram_row_timer_chk #(
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 32,
  parameter int SUM_W     = 40,
  parameter int T_ACT     = 45,
  parameter int T_CAS     = 45,
  parameter int T_PRE     = 45,
  parameter int T_BUS     = 10,
  parameter int FIXED_LAT = 100
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic [1:0]       modeSel,
  input logic             rspValid,
  input logic             rspReady,
  input logic [LAT_W-1:0] rspCycles,
  input logic [CNT_W-1:0] rdCount,
  input logic [CNT_W-1:0] wrCount,
  input logic [SUM_W-1:0] rdDelaySum,
  input logic [SUM_W-1:0] wrDelaySum
);

  logic take;
  assign take = reqValid && reqReady;

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    take |=> rspValid);

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspCycles)));

  p_busy_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> !reqReady);

  p_fixed_cost_r4: assert property (@(posedge clk) disable iff (!rstN)
    (take && (modeSel == 2'd0 || modeSel == 2'd3)) |=> (rspCycles == LAT_W'(FIXED_LAT)));

  p_open_cost_r6: assert property (@(posedge clk) disable iff (!rstN)
    (take && modeSel == 2'd1) |=>
      (rspCycles == LAT_W'(T_CAS + T_BUS) ||
       rspCycles == LAT_W'(T_ACT + T_CAS + T_BUS) ||
       rspCycles == LAT_W'(T_PRE + T_ACT + T_CAS + T_BUS)));

  p_close_cost_r8: assert property (@(posedge clk) disable iff (!rstN)
    (take && modeSel == 2'd2) |=> (rspCycles == LAT_W'(T_ACT + T_CAS + T_BUS)));

  p_rd_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (take && !reqWrite) |=> (rdCount == $past(rdCount) + 1'b1 && $stable(wrCount)));

  p_wr_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (take && reqWrite) |=> (wrCount == $past(wrCount) + 1'b1 && $stable(rdCount)));

  p_rd_sum_r10: assert property (@(posedge clk) disable iff (!rstN)
    (take && !reqWrite) |=> (rdDelaySum == $past(rdDelaySum) + SUM_W'(rspCycles)));

  p_wr_sum_r10: assert property (@(posedge clk) disable iff (!rstN)
    (take && reqWrite) |=> (wrDelaySum == $past(wrDelaySum) + SUM_W'(rspCycles)));

  p_idle_stats_r9: assert property (@(posedge clk) disable iff (!rstN)
    !take |=> ($stable(rdCount) && $stable(wrCount) && $stable(rdDelaySum) && $stable(wrDelaySum)));

endmodule

bind dram_row_timer dram_row_timer_chk #(
  .LAT_W     (LAT_W),
  .CNT_W     (CNT_W),
  .SUM_W     (SUM_W),
  .T_ACT     (T_ACT),
  .T_CAS     (T_CAS),
  .T_PRE     (T_PRE),
  .T_BUS     (T_BUS),
  .FIXED_LAT (FIXED_LAT)
) u_chk (.*);

// File: tb/tb_dram_row_timer.sv
`timescale 1ns/1ps
module tb_dram_row_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqLine = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [7:0]  rspCycles;
  logic [31:0] rdCount, wrCount;
  logic [39:0] rdDelaySum, wrDelaySum;

  int testsRun = 0;
  int testsFailed = 0;
  int expRdCnt = 0, expWrCnt = 0;
  longint expRdSum = 0, expWrSum = 0;

  always #10 clk = ~clk;  // 50 MHz

  dram_row_timer dut (.*);

  // vector: mode[42:41] line[40:9] write[8] expected cycles[7:0]
  // line = row<<8 | bank<<4 | offset (R3)
  localparam int NV = 15;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 32'h0000_0520, 1'b0, 8'd100},  // R5 idle bank 2
    {2'd1, 32'h0000_0527, 1'b1, 8'd55 },  // R6 same row, other offset
    {2'd1, 32'h0000_0920, 1'b0, 8'd145},  // R7 conflict in bank 2
    {2'd1, 32'h0000_0930, 1'b0, 8'd100},  // R3 bank 3 still idle
    {2'd1, 32'h0000_092F, 1'b0, 8'd55 },  // R7 row 9 now open
    {2'd0, 32'h0000_0120, 1'b1, 8'd100},  // R4 fixed
    {2'd1, 32'h0000_0920, 1'b0, 8'd55 },  // R4 fixed left bank 2 alone
    {2'd2, 32'h0000_0920, 1'b0, 8'd100},  // R8 close page
    {2'd1, 32'h0000_0920, 1'b0, 8'd100},  // R8 bank 2 closed after
    {2'd1, 32'h0000_0920, 1'b1, 8'd55 },  // R6 hit
    {2'd3, 32'h0000_0020, 1'b0, 8'd100},  // R4 spare code acts fixed
    {2'd1, 32'h0000_0920, 1'b1, 8'd55 },  // R4 spare left state
    {2'd1, 32'h0000_0000, 1'b0, 8'd100},  // R5 bank 0 idle
    {2'd1, 32'h0000_0005, 1'b1, 8'd55 },  // R6 bank 0 hit
    {2'd1, 32'hFFFF_FF05, 1'b0, 8'd145}   // R3 top row bits, conflict
  };

  task automatic check(input string tag, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic account(input logic wr, input int lat);
    if (wr) begin expWrCnt++; expWrSum += lat; end
    else    begin expRdCnt++; expRdSum += lat; end
  endtask

  // one request, response consumed at once; starts and ends at negedge
  task automatic runOne(input logic [1:0] m, input logic [31:0] ln, input logic wr,
                        input int expLat, input string tag);
    modeSel = m; reqLine = ln; reqWrite = wr; reqValid = 1'b1; rspReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R2 rspValid"}, rspValid, 1);
    check({tag, " cycles"}, rspCycles, expLat);
    account(wr, expLat);
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rspValid", rspValid, 0);
    check("R1 reqReady", reqReady, 1);
    check("R1 rdCount", rdCount, 0);
    check("R1 wrDelaySum", wrDelaySum, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 every bank idle: open-mode first touch of bank 9 costs 100
    runOne(2'd1, 32'h0000_0790, 1'b0, 100, "R1 idle bank");

    for (int i = 0; i < NV; i++) begin
      runOne(VEC[i][42:41], VEC[i][40:9], VEC[i][8], int'(VEC[i][7:0]),
             $sformatf("vec%0d", i));
    end

    // R2 response held while rspReady low
    modeSel = 2'd1; reqLine = 32'h0000_0A40; reqWrite = 1'b0; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqLine = 32'h0000_0B40;  // keep reqValid high: must not be taken
    account(1'b0, 100);
    for (int k = 0; k < 3; k++) begin
      check("R2 hold valid", rspValid, 1);
      check("R2 hold cycles", rspCycles, 100);
      check("R2 hold reqReady", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    check("R9 held req not counted", rdCount, expRdCnt);
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 retired", rspValid, 0);

    // R2 back-to-back: response consumed while next request taken
    modeSel = 2'd1; reqLine = 32'h0000_0370; reqWrite = 1'b1; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 b2b first cycles", rspCycles, 100);
    account(1'b1, 100);
    reqLine = 32'h0000_0375; reqWrite = 1'b0;
    check("R2 b2b reqReady", reqReady, 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 b2b second valid", rspValid, 1);
    check("R6 b2b second cycles", rspCycles, 55);
    account(1'b0, 55);
    @(posedge clk);
    @(negedge clk);
    rspReady = 1'b0;
    check("R2 b2b drained", rspValid, 0);

    // R9 R10 statistics
    check("R9 rdCount", rdCount, expRdCnt);
    check("R9 wrCount", wrCount, expWrCnt);
    check("R10 rdDelaySum", rdDelaySum, expRdSum);
    check("R10 wrDelaySum", wrDelaySum, expWrSum);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule